// File: doc/BRIEF.md
# Three-level DMA address translator

This block translates the DMA addresses issued by one PCI function into system addresses. It walks a three-level table held in system memory: a region entry, then a segment entry, then a page entry. Each level is indexed by its own bit field of the DMA address. The function's state is supplied on configuration inputs: the configured and enabled bits, the table origin, and the inclusive DMA window base and limit. Table entries are fetched through a 64-bit read port with valid/ready handshakes on both the request and the response.

A request is taken whenever the block is idle. Some outcomes need no table reads: a disabled function, the fixed doorbell address, a zero table origin and an address outside the window. These are answered in the cycle after the request. Any other request starts a walk, and its result is returned once the walk ends.

The response carries a permission code, a page address and an address mask. A failed translation also raises a fault record that holds an event code, a qualifier bit and the faulting address. A failure also sets two sticky flags, error and store-blocked. These hold until reset or until the clear input is pulsed.

Top module: `dma_xlate_walker`

## Requirements
- R1: If cfg_configured or cfg_enabled is low, an accepted request gets rsp_done in the next cycle with rsp_perm 2'b00, rsp_addr 0 and rsp_mask all ones. It causes no memory read and no fault.
- R2: A request whose address equals DOORBELL_ADDR is answered in the next cycle with rsp_addr equal to the request address, rsp_mask 0xFFF and rsp_perm 2'b11 (read/write). It causes no memory read and no fault. This applies even when the origin is zero or the address lies outside the window.
- R3: If the function is enabled and cfg_origin is zero, a non-doorbell request gets rsp_done and fault_valid in the next cycle. fault_code is 1, fault_qual is 0, fault_addr is the request address and rsp_perm is 2'b00.
- R4: An address below cfg_win_base or above cfg_win_limit (both inclusive bounds) raises fault_code 2 with qualifier 0 in the next cycle. No memory is read.
- R5: The region table base is cfg_origin with bits [11:0] cleared. Every entry address is a table base plus index times 8. The region index is address bits [41:31], the segment index is bits [30:20] and the page index is bits [19:12].
- R6: A walk reads the region entry, then the segment entry, then the page entry, one read each. The next table base is the entry with bits [11:0] cleared.
- R7: The type field is bits [3:2] of an entry. It must be 2'b11 in a region entry and 2'b10 in a segment entry, and the entry's next-table base must be nonzero. Otherwise the walk stops without further reads and raises fault_code 3 with fault_qual 1.
- R8: A page entry of zero raises fault_code 3 with fault_qual 1. A nonzero page entry with bit 10 set returns rsp_perm 2'b00, with no fault, rsp_addr equal to the entry with bits [11:0] cleared, and rsp_mask 0xFFF.
- R9: A valid page entry returns rsp_perm 2'b11, rsp_addr equal to the entry with bits [11:0] cleared, and rsp_mask 0xFFF. Every fault response carries rsp_perm 2'b00, rsp_addr 0 and rsp_mask all ones.
- R10: Only one walk runs at a time. req_ready is low from the cycle after a walk starts until the cycle its result appears, and requests offered in that time are not taken. While a read request waits for mem_rd_ready, its address stays stable.
- R11: Every fault sets err_sticky and store_block in the same cycle as fault_valid. Both flags stay set until reset or until clr_err is high at a clock edge. A fault at the same edge as clr_err leaves them set.
- R12: After reset, req_ready is 1 and rsp_done, fault_valid, mem_rd_valid, err_sticky and store_block are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_err | input | 1 | Clears the sticky flags |
| cfg_configured | input | 1 | The function is configured |
| cfg_enabled | input | 1 | The function is enabled |
| cfg_origin | input | ADDR_W | Table origin; bits [11:0] are flags |
| cfg_win_base | input | ADDR_W | Lowest DMA address allowed |
| cfg_win_limit | input | ADDR_W | Highest DMA address allowed |
| req_valid | input | 1 | Translation request |
| req_addr | input | ADDR_W | DMA address to translate |
| req_ready | output | 1 | Block is idle and takes a request |
| rsp_done | output | 1 | One-cycle result strobe |
| rsp_perm | output | 2 | 2'b11 read/write, 2'b00 none |
| rsp_addr | output | ADDR_W | Translated page address |
| rsp_mask | output | ADDR_W | Offset mask of the result |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Memory takes the read |
| mem_rd_addr | output | ADDR_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry value |
| fault_valid | output | 1 | One-cycle fault strobe |
| fault_code | output | 4 | 1 bad space, 2 out of window, 3 walk error |
| fault_qual | output | 1 | Qualifier bit of the error word |
| fault_addr | output | ADDR_W | Faulting DMA address |
| err_sticky | output | 1 | Sticky error flag |
| store_block | output | 1 | Sticky store-blocked flag |

## Verification
The bench builds the block with its default index fields (11, 11 and 8 bits) and 4 KiB pages, and passes its own doorbell address. These values let a small sparse table set cover every outcome: small region and segment indexes reach valid, wrongly typed and missing entries, and random page entries are zero, invalid or valid. The window bounds are bench inputs, so both bounds and the doorbell-over-window precedence can be reached without changing any parameter.

// File: rtl/dma_xlate_pkg.sv
package dma_xlate_pkg;
  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_ISSUE = 2'd1,
    WS_WAIT  = 2'd2
  } walk_state_e;

  typedef enum logic [1:0] {
    LV_REGION  = 2'd0,
    LV_SEGMENT = 2'd1,
    LV_PAGE    = 2'd2
  } walk_level_e;

  localparam logic [3:0] EV_BAD_SPACE     = 4'd1;
  localparam logic [3:0] EV_OUT_OF_WINDOW = 4'd2;
  localparam logic [3:0] EV_WALK_ERROR    = 4'd3;

  localparam logic [1:0] PERM_NONE = 2'b00;
  localparam logic [1:0] PERM_RW   = 2'b11;
endpackage

// File: rtl/xlate_entry_addr.sv
module xlate_entry_addr
  import dma_xlate_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int RX_LSB      = 31,
  parameter int RX_W        = 11,
  parameter int SX_LSB      = 20,
  parameter int SX_W        = 11,
  parameter int PX_LSB      = 12,
  parameter int PX_W        = 8,
  parameter int ENTRY_SHIFT = 3
) (
  input  logic [RX_LSB+RX_W-1:PX_LSB] idx_bits,
  input  walk_level_e                 level,
  input  logic [ADDR_W-1:0]           table_base,
  output logic [ADDR_W-1:0]           entry_addr
);
  localparam int NLVL = 3;

  logic [ADDR_W-1:0] idx_ext [NLVL];
  logic [ADDR_W-1:0] idx_sel;

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    localparam int LSB = (g == 0) ? RX_LSB : (g == 1) ? SX_LSB : PX_LSB;
    localparam int W   = (g == 0) ? RX_W   : (g == 1) ? SX_W   : PX_W;
    assign idx_ext[g] = {{(ADDR_W-W){1'b0}}, idx_bits[LSB+W-1:LSB]};
  end

  always_comb begin
    case (level)
      LV_REGION:  idx_sel = idx_ext[0];
      LV_SEGMENT: idx_sel = idx_ext[1];
      default:    idx_sel = idx_ext[2];
    endcase
  end

  assign entry_addr = table_base + (idx_sel << ENTRY_SHIFT);
endmodule

// File: rtl/xlate_gate.sv
module xlate_gate
  import dma_xlate_pkg::*;
#(
  parameter int                ADDR_W        = 64,
  parameter logic [ADDR_W-1:0] DOORBELL_ADDR = '0
) (
  input  logic              configured,
  input  logic              enabled,
  input  logic [ADDR_W-1:0] origin,
  input  logic [ADDR_W-1:0] win_base,
  input  logic [ADDR_W-1:0] win_limit,
  input  logic [ADDR_W-1:0] addr,
  output logic              settle,
  output logic              bypass,
  output logic [1:0]        perm,
  output logic              fault,
  output logic [3:0]        code
);
  // Decides in the accept cycle whether a walk is needed at all.
  always_comb begin
    settle = 1'b1;
    bypass = 1'b0;
    perm   = PERM_NONE;
    fault  = 1'b0;
    code   = 4'd0;
    if (!(configured && enabled)) begin
      settle = 1'b1;
    end else if (addr == DOORBELL_ADDR) begin
      bypass = 1'b1;
      perm   = PERM_RW;
    end else if (origin == '0) begin
      fault = 1'b1;
      code  = EV_BAD_SPACE;
    end else if ((addr < win_base) || (addr > win_limit)) begin
      fault = 1'b1;
      code  = EV_OUT_OF_WINDOW;
    end else begin
      settle = 1'b0;
    end
  end
endmodule

// File: rtl/xlate_entry_eval.sv
module xlate_entry_eval
  import dma_xlate_pkg::*;
#(
  parameter int         ADDR_W       = 64,
  parameter int         PAGE_SHIFT   = 12,
  parameter int         TYPE_LSB     = 2,
  parameter logic [1:0] REGION_TYPE  = 2'b11,
  parameter logic [1:0] SEGMENT_TYPE = 2'b10,
  parameter int         INVALID_BIT  = 10
) (
  input  walk_level_e       level,
  input  logic [ADDR_W-1:0] entry,
  output logic              descend,
  output logic              missing,
  output logic              usable,
  output logic [ADDR_W-1:0] frame
);
  logic [1:0] kind;
  logic       frame_nz;

  assign kind     = entry[TYPE_LSB+1:TYPE_LSB];
  assign frame    = {entry[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
  assign frame_nz = (frame != '0);

  always_comb begin
    descend = 1'b0;
    missing = 1'b0;
    usable  = 1'b0;
    case (level)
      LV_REGION: begin
        if (kind == REGION_TYPE && frame_nz) descend = 1'b1;
        else                                 missing = 1'b1;
      end
      LV_SEGMENT: begin
        if (kind == SEGMENT_TYPE && frame_nz) descend = 1'b1;
        else                                  missing = 1'b1;
      end
      default: begin
        if (entry == '0)             missing = 1'b1;
        else if (!entry[INVALID_BIT]) usable = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/xlate_sticky.sv
module xlate_sticky #(
  parameter int NFLAGS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [NFLAGS-1:0] set,
  output logic [NFLAGS-1:0] flags
);
  // Set has priority over clear.
  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~{NFLAGS{clr}}) | set;
  end
endmodule

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker
  import dma_xlate_pkg::*;
#(
  parameter int                ADDR_W        = 64,
  parameter int                RX_LSB        = 31,
  parameter int                RX_W          = 11,
  parameter int                SX_LSB        = 20,
  parameter int                SX_W          = 11,
  parameter int                PX_LSB        = 12,
  parameter int                PX_W          = 8,
  parameter int                PAGE_SHIFT    = 12,
  parameter logic [ADDR_W-1:0] DOORBELL_ADDR = 64'h0000_0000_0FFF_E000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_err,
  input  logic              cfg_configured,
  input  logic              cfg_enabled,
  input  logic [ADDR_W-1:0] cfg_origin,
  input  logic [ADDR_W-1:0] cfg_win_base,
  input  logic [ADDR_W-1:0] cfg_win_limit,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [1:0]        rsp_perm,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [ADDR_W-1:0] rsp_mask,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              fault_valid,
  output logic [3:0]        fault_code,
  output logic              fault_qual,
  output logic [ADDR_W-1:0] fault_addr,
  output logic              err_sticky,
  output logic              store_block
);
  localparam logic [ADDR_W-1:0] PAGE_MASK =
    {{(ADDR_W-PAGE_SHIFT){1'b0}}, {PAGE_SHIFT{1'b1}}};
  localparam int ENTRY_SHIFT = 3;

  walk_state_e       state;
  walk_level_e       level;
  walk_level_e       next_level;
  walk_level_e       level_src;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic [ADDR_W-1:0] idx_src;
  logic [ADDR_W-1:0] base_src;
  logic [ADDR_W-1:0] origin_base;
  logic [ADDR_W-1:0] entry_addr;

  logic              gate_settle, gate_bypass, gate_fault;
  logic [1:0]        gate_perm;
  logic [3:0]        gate_code;

  logic              ev_descend, ev_missing, ev_usable;
  logic [ADDR_W-1:0] ev_frame;
  logic [ADDR_W-1:0] entry_word;

  logic              fault_fire;
  logic [1:0]        flags;

  assign req_ready    = (state == WS_IDLE);
  assign mem_rd_valid = (state == WS_ISSUE);
  assign mem_rd_addr  = rd_addr;
  assign entry_word   = mem_rsp_data[ADDR_W-1:0];

  assign origin_base = {cfg_origin[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
  assign next_level  = (level == LV_REGION) ? LV_SEGMENT : LV_PAGE;
  assign level_src   = (state == WS_IDLE) ? LV_REGION : next_level;
  assign idx_src     = (state == WS_IDLE) ? req_addr : cur_addr;
  assign base_src    = (state == WS_IDLE) ? origin_base : ev_frame;

  xlate_gate #(
    .ADDR_W        (ADDR_W),
    .DOORBELL_ADDR (DOORBELL_ADDR)
  ) u_gate (
    .configured (cfg_configured),
    .enabled    (cfg_enabled),
    .origin     (cfg_origin),
    .win_base   (cfg_win_base),
    .win_limit  (cfg_win_limit),
    .addr       (req_addr),
    .settle     (gate_settle),
    .bypass     (gate_bypass),
    .perm       (gate_perm),
    .fault      (gate_fault),
    .code       (gate_code)
  );

  xlate_entry_addr #(
    .ADDR_W      (ADDR_W),
    .RX_LSB      (RX_LSB),
    .RX_W        (RX_W),
    .SX_LSB      (SX_LSB),
    .SX_W        (SX_W),
    .PX_LSB      (PX_LSB),
    .PX_W        (PX_W),
    .ENTRY_SHIFT (ENTRY_SHIFT)
  ) u_eaddr (
    .idx_bits   (idx_src[RX_LSB+RX_W-1:PX_LSB]),
    .level      (level_src),
    .table_base (base_src),
    .entry_addr (entry_addr)
  );

  xlate_entry_eval #(
    .ADDR_W     (ADDR_W),
    .PAGE_SHIFT (PAGE_SHIFT)
  ) u_eval (
    .level   (level),
    .entry   (entry_word),
    .descend (ev_descend),
    .missing (ev_missing),
    .usable  (ev_usable),
    .frame   (ev_frame)
  );

  assign fault_fire =
    ((state == WS_IDLE) && req_valid && gate_settle && gate_fault) ||
    ((state == WS_WAIT) && mem_rsp_valid && ev_missing);

  xlate_sticky #(.NFLAGS(2)) u_sticky (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr_err),
    .set   ({2{fault_fire}}),
    .flags (flags)
  );

  assign err_sticky  = flags[0];
  assign store_block = flags[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= WS_IDLE;
      level       <= LV_REGION;
      cur_addr    <= '0;
      rd_addr     <= '0;
      rsp_done    <= 1'b0;
      rsp_perm    <= PERM_NONE;
      rsp_addr    <= '0;
      rsp_mask    <= '0;
      fault_valid <= 1'b0;
      fault_code  <= 4'd0;
      fault_qual  <= 1'b0;
      fault_addr  <= '0;
    end else begin
      rsp_done    <= 1'b0;
      fault_valid <= 1'b0;
      case (state)
        WS_IDLE: begin
          if (req_valid) begin
            cur_addr <= req_addr;
            if (gate_settle) begin
              rsp_done <= 1'b1;
              rsp_perm <= gate_perm;
              rsp_addr <= gate_bypass ? req_addr : '0;
              rsp_mask <= gate_bypass ? PAGE_MASK : '1;
              if (gate_fault) begin
                fault_valid <= 1'b1;
                fault_code  <= gate_code;
                fault_qual  <= 1'b0;
                fault_addr  <= req_addr;
              end
            end else begin
              state   <= WS_ISSUE;
              level   <= LV_REGION;
              rd_addr <= entry_addr;
            end
          end
        end
        WS_ISSUE: begin
          if (mem_rd_ready) state <= WS_WAIT;
        end
        WS_WAIT: begin
          if (mem_rsp_valid) begin
            if (ev_descend) begin
              level   <= next_level;
              rd_addr <= entry_addr;
              state   <= WS_ISSUE;
            end else begin
              state    <= WS_IDLE;
              rsp_done <= 1'b1;
              if (ev_missing) begin
                rsp_perm    <= PERM_NONE;
                rsp_addr    <= '0;
                rsp_mask    <= '1;
                fault_valid <= 1'b1;
                fault_code  <= EV_WALK_ERROR;
                fault_qual  <= 1'b1;
                fault_addr  <= cur_addr;
              end else begin
                rsp_perm <= ev_usable ? PERM_RW : PERM_NONE;
                rsp_addr <= ev_frame;
                rsp_mask <= PAGE_MASK;
              end
            end
          end
        end
        default: state <= WS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_xlate_walker_chk.sv
module dma_xlate_walker_chk #(
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              clr_err,
  input logic              cfg_configured,
  input logic              cfg_enabled,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [1:0]        rsp_perm,
  input logic [ADDR_W-1:0] rsp_mask,
  input logic              mem_rd_valid,
  input logic              mem_rd_ready,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              fault_valid,
  input logic              err_sticky,
  input logic              store_block
);
  localparam logic [ADDR_W-1:0] PAGE_MASK =
    {{(ADDR_W-PAGE_SHIFT){1'b0}}, {PAGE_SHIFT{1'b1}}};

  // R1
  off_fn_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && !(cfg_configured && cfg_enabled)
    |=> rsp_done && rsp_perm == 2'b00 && !fault_valid)
    else $error("off_fn_chk");

  // R10
  busy_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> !req_ready)
    else $error("busy_refuse_chk");

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr))
    else $error("rd_hold_chk");

  // R5
  rd_align_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> mem_rd_addr[2:0] == 3'b000)
    else $error("rd_align_chk");

  // R9
  rw_mask_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done && rsp_perm == 2'b11 |-> rsp_mask == PAGE_MASK)
    else $error("rw_mask_chk");

  // R9
  fault_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> rsp_done && rsp_perm == 2'b00)
    else $error("fault_rsp_chk");

  // R11
  fault_flags_chk: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> err_sticky && store_block)
    else $error("fault_flags_chk");

  // R11
  flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
    err_sticky && !clr_err |=> err_sticky)
    else $error("flag_keep_chk");
endmodule

bind dma_xlate_walker dma_xlate_walker_chk #(
  .ADDR_W     (ADDR_W),
  .PAGE_SHIFT (PAGE_SHIFT)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .clr_err        (clr_err),
  .cfg_configured (cfg_configured),
  .cfg_enabled    (cfg_enabled),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .rsp_done       (rsp_done),
  .rsp_perm       (rsp_perm),
  .rsp_mask       (rsp_mask),
  .mem_rd_valid   (mem_rd_valid),
  .mem_rd_ready   (mem_rd_ready),
  .mem_rd_addr    (mem_rd_addr),
  .fault_valid    (fault_valid),
  .err_sticky     (err_sticky),
  .store_block    (store_block)
);

// File: tb/tb_dma_xlate_walker.sv
`timescale 1ns/1ps
module tb_dma_xlate_walker;
  localparam logic [63:0] DOOR = 64'h0000_0000_0FFF_E000;
  localparam logic [63:0] LOWM = 64'hFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr_err = 1'b0;
  logic        c_conf = 1'b1, c_en = 1'b1;
  logic [63:0] c_org = 64'h0010_0005;
  logic [63:0] c_base = 64'h1000;
  logic [63:0] c_lim = 64'h3FF_FFFF_FFFF;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        req_ready, rsp_done, fault_valid, fault_qual, err_sticky, store_block;
  logic [1:0]  rsp_perm;
  logic [63:0] rsp_addr, rsp_mask, fault_addr, mem_rd_addr;
  logic [3:0]  fault_code;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  int tests = 0, failed = 0;
  logic [63:0] mem [logic [63:0]];
  int          nrd;
  logic [63:0] rd_log [4];
  bit          pend;
  logic [63:0] pend_addr;
  int          dly;
  bit          exp_sticky;

  logic [1:0]  e_perm;
  logic [63:0] e_addr, e_mask;
  bit          e_fault, e_qual;
  logic [3:0]  e_code;
  int          e_n;
  logic [63:0] e_rd [3];
  string       e_tag;

  always #2 clk = ~clk;

  dma_xlate_walker #(.DOORBELL_ADDR(DOOR)) dut (
    .clk(clk), .rst(rst), .clr_err(clr_err),
    .cfg_configured(c_conf), .cfg_enabled(c_en), .cfg_origin(c_org),
    .cfg_win_base(c_base), .cfg_win_limit(c_lim),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_perm(rsp_perm), .rsp_addr(rsp_addr), .rsp_mask(rsp_mask),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .fault_valid(fault_valid), .fault_code(fault_code), .fault_qual(fault_qual),
    .fault_addr(fault_addr), .err_sticky(err_sticky), .store_block(store_block)
  );

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Reference model built from the requirements.
  function automatic void model(input logic [63:0] a);
    logic [63:0] t, e;
    e_perm = 2'b00; e_addr = '0; e_mask = '1; e_fault = 0; e_qual = 0;
    e_code = 4'd0; e_n = 0; e_tag = "R9";
    if (!(c_conf && c_en)) begin e_tag = "R1"; return; end
    if (a == DOOR) begin e_tag = "R2"; e_perm = 2'b11; e_addr = a; e_mask = LOWM; return; end
    if (c_org == 0) begin e_tag = "R3"; e_fault = 1; e_code = 4'd1; return; end
    if (a < c_base || a > c_lim) begin e_tag = "R4"; e_fault = 1; e_code = 4'd2; return; end
    t = c_org & ~LOWM;
    e_rd[0] = t + {53'd0, a[41:31]} * 8; e = rd(e_rd[0]); e_n = 1;
    if (e[3:2] != 2'b11 || (e & ~LOWM) == 0) begin
      e_tag = "R7"; e_fault = 1; e_code = 4'd3; e_qual = 1; return;
    end
    t = e & ~LOWM;
    e_rd[1] = t + {53'd0, a[30:20]} * 8; e = rd(e_rd[1]); e_n = 2;
    if (e[3:2] != 2'b10 || (e & ~LOWM) == 0) begin
      e_tag = "R7"; e_fault = 1; e_code = 4'd3; e_qual = 1; return;
    end
    t = e & ~LOWM;
    e_rd[2] = t + {56'd0, a[19:12]} * 8; e = rd(e_rd[2]); e_n = 3;
    if (e == 0) begin e_tag = "R8"; e_fault = 1; e_code = 4'd3; e_qual = 1; return; end
    e_addr = e & ~LOWM; e_mask = LOWM;
    if (e[10]) begin e_tag = "R8"; e_perm = 2'b00; end
    else e_perm = 2'b11;
  endfunction

  // Memory responder: random ready, 0..2 cycles of read latency.
  initial begin
    pend = 0; nrd = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid = 1'b1; mem_rsp_data = rd(pend_addr); pend = 0;
        end else dly--;
      end
      mem_rd_ready = (($urandom % 4) != 0);
      if (mem_rd_valid && mem_rd_ready && !pend) begin
        pend = 1; pend_addr = mem_rd_addr; dly = $urandom % 3;
        if (nrd < 4) rd_log[nrd] = mem_rd_addr;
        nrd++;
      end
    end
  end

  task automatic run_req(input logic [63:0] a, input bit poke_in, input bit clr_with);
    int  n;
    bit  busy_bad;
    bit  poke;
    model(a);
    poke = poke_in && (e_n > 0);
    @(negedge clk);
    nrd = 0; req_valid = 1'b1; req_addr = a; clr_err = clr_with;
    @(negedge clk);
    req_valid = poke; req_addr = a ^ 64'h1000; clr_err = 1'b0;
    n = 0; busy_bad = 0;
    while (!rsp_done && n < 400) begin
      if (req_ready) busy_bad = 1;
      n++;
      @(negedge clk);
      if (n >= 2) req_valid = 1'b0;
    end
    req_valid = 1'b0;
    if (clr_with) exp_sticky = 0;
    if (e_fault) exp_sticky = 1;
    chk(n < 400, e_tag, "response arrived", 64'(n), 64'd0);
    chk(rsp_perm == e_perm, e_tag, "rsp_perm", 64'(rsp_perm), 64'(e_perm));
    chk(rsp_addr == e_addr, e_tag, "rsp_addr", rsp_addr, e_addr);
    chk(rsp_mask == e_mask, e_tag, "rsp_mask", rsp_mask, e_mask);
    chk(fault_valid == e_fault, e_tag, "fault_valid", 64'(fault_valid), 64'(e_fault));
    if (e_fault) begin
      chk(fault_code == e_code, e_tag, "fault_code", 64'(fault_code), 64'(e_code));
      chk(fault_qual == e_qual, e_tag, "fault_qual", 64'(fault_qual), 64'(e_qual));
      chk(fault_addr == a, e_tag, "fault_addr", fault_addr, a);
    end
    chk(nrd == e_n, "R6", "read count", 64'(nrd), 64'(e_n));
    for (int i = 0; i < 3; i++)
      if (i < e_n && i < nrd)
        chk(rd_log[i] == e_rd[i], "R5", "entry address", rd_log[i], e_rd[i]);
    chk(err_sticky == exp_sticky && store_block == exp_sticky, "R11", "sticky flags",
        64'({err_sticky, store_block}), 64'({exp_sticky, exp_sticky}));
    if (e_n > 0) chk(!busy_bad, "R10", "req_ready low during walk", 64'(busy_bad), 64'd0);
    if (poke) begin
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        chk(!rsp_done, "R10", "no response to refused request", 64'(rsp_done), 64'd0);
      end
      chk(nrd == e_n, "R10", "no reads for refused request", 64'(nrd), 64'(e_n));
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk); clr_err = 1'b1;
    @(negedge clk); clr_err = 1'b0;
    exp_sticky = 0;
    chk(!err_sticky && !store_block, "R11", "flags after clear",
        64'({err_sticky, store_block}), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failed++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    logic [63:0] pt, a, fr;
    void'($urandom(32'd4711));
    exp_sticky = 0;
    // Region table at 0x100000 (origin carries flag bits 0x5).
    mem[64'h100000] = 64'h200000 | 64'hC;
    mem[64'h100008] = 64'h300000 | 64'hC;
    mem[64'h100010] = 64'h400000 | 64'h8;   // wrong type
    for (int t = 0; t < 2; t++) begin
      for (int s = 0; s < 3; s++)
        mem[64'h200000 + 64'(t) * 64'h100000 + 64'(s) * 8] =
          (64'h500000 + 64'(t * 4 + s) * 64'h1000) | 64'h8;
      mem[64'h200000 + 64'(t) * 64'h100000 + 24] = 64'h600000 | 64'h4; // wrong type
      for (int s = 0; s < 3; s++) begin
        pt = 64'h500000 + 64'(t * 4 + s) * 64'h1000;
        for (int p = 0; p < 8; p++) begin
          fr = 64'(($urandom % 32'hFFFFF) + 1) << 12;
          case ($urandom % 4)
            0: mem[pt + 64'(p) * 8] = 64'd0;
            1: mem[pt + 64'(p) * 8] = fr | 64'h400;
            default: mem[pt + 64'(p) * 8] = fr | 64'($urandom % 32'h3FF);
          endcase
        end
      end
    end
    mem[64'h500008] = 64'd0;
    mem[64'h500010] = 64'h0000_0001_2345_6400;
    mem[64'h500018] = 64'h0000_0007_89AB_C2FF;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(req_ready && !rsp_done && !fault_valid && !mem_rd_valid && !err_sticky && !store_block,
        "R12", "reset state",
        64'({req_ready, rsp_done, fault_valid, mem_rd_valid, err_sticky, store_block}),
        64'b100000);

    // R9 / R5 / R6 valid walk, R8 zero and invalid page entries
    run_req(64'h3000, 0, 0);
    run_req(64'h2000, 0, 0);
    run_req(64'h1000, 0, 0);
    pulse_clear();
    // R7 wrong-type region, missing region, wrong-type segment
    run_req(64'h1_0000_0000, 0, 0);
    run_req(64'h1_8000_0000, 0, 0);
    run_req(64'h0030_1000, 0, 0);
    // R11 flags survive a good walk, then clear
    run_req(64'h3000, 0, 0);
    pulse_clear();
    // R1 not configured, not enabled
    c_conf = 0; run_req(64'h3000, 0, 0);
    c_conf = 1; c_en = 0; run_req(64'h3000, 0, 0);
    c_en = 1;
    // R4 below base and above limit
    run_req(64'h0800, 0, 0);
    c_lim = 64'h0FFF_0000; run_req(64'h0FFF_1000, 0, 0);
    // R2 doorbell outside window and with zero origin
    run_req(DOOR, 0, 0);
    c_org = 64'd0; run_req(DOOR, 0, 0);
    // R3 zero origin
    run_req(64'h3000, 0, 0);
    // R11 fault in the same cycle as clear keeps flags set
    run_req(64'h5000, 0, 1);
    c_org = 64'h0010_0005; c_lim = 64'h3FF_FFFF_FFFF;
    // R10 request offered during a walk is refused
    run_req(64'h3000, 1, 1);

    for (int it = 0; it < 300; it++) begin
      a = (64'($urandom % 4) << 31) | (64'($urandom % 4) << 20) |
          (64'($urandom % 8) << 12) | 64'($urandom % 4096);
      if (($urandom % 16) == 0) a = DOOR;
      run_req(a, ($urandom % 8) == 0, ($urandom % 10) == 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule